// File: doc/BRIEF.md
# DMA Channel Start Queue Controller

This block sits in front of the data movers of a ten-channel DMA controller and handles processor writes to each channel's control word. A write that sets a channel's start bit either launches that channel at once or, when the DMA is globally disabled, is recorded in a pending bitmap. The bitmap is replayed later. Launches reach the data movers as one-cycle strobes, one bit per channel.

The block also handles a few side effects of control-word writes. In chain mode, a word write that carries no tag keeps the stored tag half. A control write clears the channel's transfer count when the count has bits set above bit 15. A start issued to a channel that is already running while the DMA is enabled raises a busy pulse. When the global enable bit goes from 0 to 1, the queued channels launch one per cycle, lowest channel index first.

Top module: `dma_start_queue`

## Requirements
- R1: After reset, all control words, all count registers, the global control register, the pending bitmap, `launch_o` and `busy_err_o` are zero.
- R2: A byte write (size 0) replaces only byte lane `wr_lane_i` of the control word. Bit 0 of the data is the start request only when the lane is 1.
- R3: A halfword write (size 1) replaces bits 15:0 of the control word and leaves bits 31:16 unchanged. Data bit 8 is the start request.
- R4: A word write (size 2) stores the full 32-bit value. The exception is a word whose bits 3:2 are 01 (chain mode) and whose bits 31:16 are zero: in that case bits 31:16 keep their old value. Data bit 8 is the start request. Size 3 writes nothing.
- R5: On the clock edge that stores a control write, if the stored bit 8 is 1 and global enable (bit 0 of the global control register) is 1, that channel's `launch_o` bit is high for the following cycle.
- R6: A start request written while global enable is 0 sets that channel's pending bit and launches nothing. Pending bits never become set while enable is 1.
- R7: A global-control write that changes enable from 0 to 1 starts a replay. From the next edge onward, each edge launches the lowest-numbered pending channel and clears its pending bit. There is one launch per cycle, in ascending order, until the bitmap is empty.
- R8: A control write to a channel whose count register has any of bits 31:16 set clears that count register to zero. Otherwise the count is untouched. A count write (`wr_tgt_i`=1) stores all 32 data bits, whatever the size.
- R9: A start request to a channel whose stored bit 8 is already 1, while enable is 1, produces a one-cycle `busy_err_o` pulse. The write is still processed as in R5.
- R10: A global-control write with bit 0 clear stops an ongoing replay after the edge that stores it. Channels still pending keep their bits and launch on the next 0-to-1 change of enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_tgt_i | input | 1 | 0 = control word, 1 = transfer count |
| wr_ch_i | input | 4 | Channel index (0..9) |
| wr_size_i | input | 2 | 0 = byte, 1 = halfword, 2 = word |
| wr_lane_i | input | 2 | Byte lane for byte writes |
| wr_data_i | input | 32 | Write data (byte/halfword right-aligned) |
| gctl_we_i | input | 1 | Global control write strobe |
| gctl_data_i | input | 32 | Global control write data, bit 0 = enable |
| gctl_o | output | 32 | Global control register |
| rd_ch_i | input | 4 | Read-back channel index |
| rd_ctrl_o | output | 32 | Control word of `rd_ch_i` |
| rd_cnt_o | output | 32 | Count register of `rd_ch_i` |
| pend_o | output | 10 | Pending start bitmap |
| launch_o | output | 10 | One-cycle launch strobes |
| busy_err_o | output | 1 | Start-while-running pulse |

## Verification
The hardest case to reach is an interrupted replay. It needs several channels queued while the DMA is disabled, then enable raised, then enable dropped again in the middle of the launch train. The stimulus builds this from directed global-control writes timed at the cycle of the first replay launch. It then checks which channels still launch before the halt takes effect and which remain pending. Random writes mix sizes and lanes, force the chain-mode zero-tag pattern on some writes, load count registers with random upper halves, and toggle enable, so that queueing and replay recur with many different bitmaps.

// File: rtl/dq_pkg.sv
package dq_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned START_BIT = 8;
  localparam logic [1:0]  MODE_CHAIN = 2'b01;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } wr_size_e;
endpackage

// File: rtl/dq_ctrl_regs.sv
module dq_ctrl_regs
  import dq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_tgt_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [1:0]        wr_size_i,
  input  logic [1:0]        wr_lane_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [WORD_W-1:0] rd_ctrl_o,
  output logic [WORD_W-1:0] rd_cnt_o,
  output logic              ctrl_wr_o,
  output logic              start_req_o,
  output logic              old_start_o,
  output logic              new_start_o
);
  logic [WORD_W-1:0] ctrl_q [NUM_CH];
  logic [WORD_W-1:0] cnt_q  [NUM_CH];
  logic              ch_ok, rd_ok, cnt_wr, keep_tag;
  logic [CH_W-1:0]   ch_idx;
  logic [WORD_W-1:0] cur_word, merged;
  wr_size_e          size;

  assign size     = wr_size_e'(wr_size_i);
  assign ch_ok    = {1'b0, wr_ch_i} < (CH_W+1)'(NUM_CH);
  assign rd_ok    = {1'b0, rd_ch_i} < (CH_W+1)'(NUM_CH);
  assign ch_idx   = ch_ok ? wr_ch_i : '0;
  assign cur_word = ctrl_q[ch_idx];
  assign ctrl_wr_o = wr_en_i && !wr_tgt_i && ch_ok && (size != SZ_NONE);
  assign cnt_wr    = wr_en_i &&  wr_tgt_i && ch_ok;

  always_comb begin
    merged      = cur_word;
    start_req_o = 1'b0;
    keep_tag    = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        merged[8*wr_lane_i +: 8] = wr_data_i[7:0];
        start_req_o = (wr_lane_i == 2'd1) && wr_data_i[0];
      end
      SZ_HALF: begin
        merged[15:0] = wr_data_i[15:0];
        start_req_o  = wr_data_i[START_BIT];
      end
      SZ_WORD: begin
        keep_tag    = (wr_data_i[3:2] == MODE_CHAIN) && (wr_data_i[31:16] == '0);
        merged      = keep_tag ? {cur_word[31:16], wr_data_i[15:0]} : wr_data_i;
        start_req_o = wr_data_i[START_BIT];
      end
      default: ;
    endcase
  end

  assign old_start_o = cur_word[START_BIT];
  assign new_start_o = merged[START_BIT];
  assign rd_ctrl_o   = rd_ok ? ctrl_q[rd_ok ? rd_ch_i : '0] : '0;
  assign rd_cnt_o    = rd_ok ? cnt_q[rd_ok ? rd_ch_i : '0]  : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic sel;
    assign sel = (ch_idx == CH_W'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_q[c] <= '0;
        cnt_q[c]  <= '0;
      end else if (sel && ctrl_wr_o) begin
        ctrl_q[c] <= merged;
        if (cnt_q[c][31:16] != '0) cnt_q[c] <= '0;
      end else if (sel && cnt_wr) begin
        cnt_q[c] <= wr_data_i;
      end
    end

    assert_tag_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_o && sel && keep_tag && size == SZ_WORD)
        |=> (ctrl_q[c][31:16] == $past(ctrl_q[c][31:16])));

    assert_cnt_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_wr_o && sel && cnt_q[c][31:16] != '0) |=> (cnt_q[c] == '0));
  end
endmodule

// File: rtl/dq_start_queue.sv
module dq_start_queue #(
  parameter int unsigned NUM_CH = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rise_i,
  input  logic              halt_i,
  input  logic [NUM_CH-1:0] set_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] rep_launch_o
);
  logic [NUM_CH-1:0] pend_q, pick;
  logic              rep_q, fire;

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (pend_q[i]) pick = NUM_CH'(1) << i;
  end

  assign fire         = rep_q && en_i && (pend_q != '0);
  assign rep_launch_o = fire ? pick : '0;
  assign pend_o       = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      rep_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~rep_launch_o) | set_i;
      if (halt_i)                                   rep_q <= 1'b0;
      else if (rise_i)                              rep_q <= 1'b1;
      else if (fire && ((pend_q & ~pick) == '0))    rep_q <= 1'b0;
    end
  end

  assert_single_replay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rep_launch_o));

  assert_replay_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rep_launch_o != '0) |=> ((pend_q & $past(rep_launch_o)) == '0));

  assert_no_queue_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/dma_start_queue.sv
module dma_start_queue
  import dq_pkg::*;
#(
  parameter int unsigned NUM_CH = 10,
  parameter int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_tgt_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [1:0]        wr_size_i,
  input  logic [1:0]        wr_lane_i,
  input  logic [31:0]       wr_data_i,
  input  logic              gctl_we_i,
  input  logic [31:0]       gctl_data_i,
  output logic [31:0]       gctl_o,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [31:0]       rd_ctrl_o,
  output logic [31:0]       rd_cnt_o,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] launch_o,
  output logic              busy_err_o
);
  logic [31:0]       gctl_q;
  logic              en_q, ctrl_wr, start_req, old_start, new_start, rise, halt;
  logic [NUM_CH-1:0] ch_vec, imm_vec, set_vec, rep_launch, launch_q;
  logic              err_q;

  dq_ctrl_regs #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_tgt_i, .wr_ch_i, .wr_size_i, .wr_lane_i,
    .wr_data_i, .rd_ch_i, .rd_ctrl_o, .rd_cnt_o,
    .ctrl_wr_o(ctrl_wr), .start_req_o(start_req),
    .old_start_o(old_start), .new_start_o(new_start)
  );

  assign en_q    = gctl_q[0];
  assign rise    = gctl_we_i && !en_q && gctl_data_i[0];
  assign halt    = gctl_we_i && !gctl_data_i[0];
  assign ch_vec  = NUM_CH'(1) << wr_ch_i;
  assign imm_vec = (ctrl_wr && new_start && en_q) ? ch_vec : '0;
  assign set_vec = (ctrl_wr && start_req && !en_q) ? ch_vec : '0;

  dq_start_queue #(.NUM_CH(NUM_CH)) u_queue (
    .clk_i, .rst_ni, .en_i(en_q), .rise_i(rise), .halt_i(halt),
    .set_i(set_vec), .pend_o, .rep_launch_o(rep_launch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gctl_q   <= '0;
      launch_q <= '0;
      err_q    <= 1'b0;
    end else begin
      if (gctl_we_i) gctl_q <= gctl_data_i;
      launch_q <= imm_vec | rep_launch;
      err_q    <= ctrl_wr && start_req && old_start && en_q;
    end
  end

  assign gctl_o     = gctl_q;
  assign launch_o   = launch_q;
  assign busy_err_o = err_q;

  assert_launch_needs_en_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (launch_o != '0) |-> $past(en_q));

  assert_busy_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |-> $past(en_q));

  assert_pulse_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_err_o |-> $past(ctrl_wr));
endmodule

// File: tb/tb_dma_start_queue.sv
module tb_dma_start_queue;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 10;

  logic        clk = 0, rst_ni = 0;
  logic        wr_en_i = 0, wr_tgt_i = 0, gctl_we_i = 0;
  logic [3:0]  wr_ch_i = 0, rd_ch_i = 0;
  logic [1:0]  wr_size_i = 0, wr_lane_i = 0;
  logic [31:0] wr_data_i = 0, gctl_data_i = 0;
  logic [31:0] gctl_o, rd_ctrl_o, rd_cnt_o;
  logic [NCH-1:0] pend_o, launch_o;
  logic        busy_err_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] ctrl_m [NCH];
  logic [31:0] cnt_m  [NCH];
  logic [NCH-1:0] pend_m;
  logic en_m;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_start_queue dut (
    .clk_i(clk), .rst_ni, .wr_en_i, .wr_tgt_i, .wr_ch_i, .wr_size_i, .wr_lane_i,
    .wr_data_i, .gctl_we_i, .gctl_data_i, .gctl_o, .rd_ch_i, .rd_ctrl_o,
    .rd_cnt_o, .pend_o, .launch_o, .busy_err_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_merge(logic [31:0] old, int sz, int ln,
                                            logic [31:0] d, output logic st);
    logic [31:0] r = old;
    st = 0;
    case (sz)
      0: begin r[8*ln +: 8] = d[7:0]; st = (ln == 1) && d[0]; end
      1: begin r[15:0] = d[15:0]; st = d[8]; end
      2: begin
        if (d[3:2] == 2'b01 && d[31:16] == 0) r = {old[31:16], d[15:0]};
        else r = d;
        st = d[8];
      end
      default: ;
    endcase
    return r;
  endfunction

  task automatic do_wr(bit tgt, int ch, int sz, int ln, logic [31:0] d);
    logic st, exp_err;
    logic [NCH-1:0] exp_l = '0;
    logic [31:0] nw;
    exp_err = 0;
    if (!tgt && sz != 3) begin
      nw = ref_merge(ctrl_m[ch], sz, ln, d, st);
      if (nw[8] && en_m) exp_l[ch] = 1'b1;
      exp_err = st && ctrl_m[ch][8] && en_m;
      if (st && !en_m) pend_m[ch] = 1'b1;
      if (cnt_m[ch][31:16] != 0) cnt_m[ch] = 0;
      ctrl_m[ch] = nw;
    end else if (tgt) cnt_m[ch] = d;
    @(negedge clk);
    wr_en_i = 1; wr_tgt_i = tgt; wr_ch_i = 4'(ch); wr_size_i = 2'(sz);
    wr_lane_i = 2'(ln); wr_data_i = d; rd_ch_i = 4'(ch);
    @(negedge clk);
    wr_en_i = 0;
    chk("R5 launch", 32'(launch_o), 32'(exp_l));
    chk("R9 busy", 32'(busy_err_o), 32'(exp_err));
    chk("R6 pend", 32'(pend_o), 32'(pend_m));
    chk("R2/R3/R4 ctrl", rd_ctrl_o, ctrl_m[ch]);
    chk("R8 cnt", rd_cnt_o, cnt_m[ch]);
  endtask

  task automatic set_en(bit v);
    bit rising = !en_m && v;
    @(negedge clk);
    gctl_we_i = 1; gctl_data_i = {$urandom() & 32'hFFFF_FFFE} | 32'(v);
    @(negedge clk);
    gctl_we_i = 0;
    en_m = v;
    chk("R7 gctl", 32'(gctl_o[0]), 32'(v));
    chk("R7 no launch at write", 32'(launch_o), 0);
    if (rising) begin
      for (int i = 0; i < NCH; i++) begin
        if (pend_m[i]) begin
          @(negedge clk);
          pend_m[i] = 1'b0;
          chk("R7 replay order", 32'(launch_o), 32'(1) << i);
          chk("R7 pend clear", 32'(pend_o), 32'(pend_m));
        end
      end
      @(negedge clk);
      chk("R7 replay done", 32'(launch_o), 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < NCH; i++) begin ctrl_m[i] = 0; cnt_m[i] = 0; end
    pend_m = 0; en_m = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pend", 32'(pend_o), 0);
    chk("R1 launch", 32'(launch_o), 0);
    chk("R1 busy", 32'(busy_err_o), 0);
    chk("R1 gctl", gctl_o, 0);
    for (int i = 0; i < NCH; i++) begin
      rd_ch_i = 4'(i); #1;
      chk("R1 ctrl", rd_ctrl_o, 0);
      chk("R1 cnt", rd_cnt_o, 0);
    end
    // R2 byte lanes, R3 halfword, R4 tag keep
    do_wr(0, 3, 2, 0, 32'hABCD_0044);
    do_wr(0, 3, 0, 2, 32'h0000_0077);
    do_wr(0, 3, 1, 0, 32'h1234_5600);
    do_wr(0, 3, 2, 0, 32'h0000_0004);
    do_wr(0, 3, 2, 0, 32'h0000_0008);
    // R8 count clear
    do_wr(1, 4, 2, 0, 32'h0001_0010);
    do_wr(0, 4, 2, 0, 32'h0000_0000);
    do_wr(1, 4, 2, 0, 32'h0000_FFFF);
    do_wr(0, 4, 2, 0, 32'h0000_0000);
    // R6 queue while disabled, R2 byte start lane 1
    do_wr(0, 7, 0, 1, 32'h0000_0001);
    do_wr(0, 2, 2, 0, 32'h0000_0100);
    do_wr(0, 5, 1, 0, 32'h0000_0100);
    do_wr(0, 6, 0, 0, 32'h0000_0001);
    // R7 replay
    set_en(1);
    // R5 immediate, R9 busy
    do_wr(0, 1, 2, 0, 32'h0000_0104);
    do_wr(0, 1, 1, 0, 32'h0000_0100);
    do_wr(0, 1, 1, 0, 32'h0000_0000);
    // R10 halt mid-replay
    set_en(0);
    do_wr(0, 2, 2, 0, 32'h0000_0100);
    do_wr(0, 5, 2, 0, 32'h0000_0100);
    do_wr(0, 7, 2, 0, 32'h0000_0100);
    @(negedge clk); gctl_we_i = 1; gctl_data_i = 1;
    @(negedge clk); gctl_we_i = 0; en_m = 1;
    chk("R10 no launch yet", 32'(launch_o), 0);
    @(negedge clk); gctl_we_i = 1; gctl_data_i = 0;
    chk("R10 first", 32'(launch_o), 32'(1) << 2);
    @(negedge clk); gctl_we_i = 0; en_m = 0;
    pend_m[2] = 0; pend_m[5] = 0;
    chk("R10 second", 32'(launch_o), 32'(1) << 5);
    chk("R10 pend kept", 32'(pend_o), 32'(pend_m));
    @(negedge clk);
    chk("R10 halted", 32'(launch_o), 0);
    chk("R10 pend still", 32'(pend_o), 32'(pend_m));
    set_en(1);
    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 99);
      int ch = $urandom_range(0, NCH - 1);
      logic [31:0] d = $urandom();
      if (op < 12) set_en(1'($urandom_range(0, 1)));
      else if (op < 30) do_wr(1, ch, 2, 0, d);
      else begin
        if ($urandom_range(0, 3) == 0) d = {16'h0, d[15:4], 2'b01, d[1:0]};
        do_wr(0, ch, $urandom_range(0, 3), $urandom_range(0, 3), d);
      end
    end
    set_en(1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule